// File: doc/BRIEF.md
# Flash Card Task-File Register Emulator

This block is the device side of the 8-bit command interface of a removable flash card. A host selects one of eight task-file registers with a 3-bit address and pulses an active-low write strobe to load it or an active-low output-enable strobe to read it. At two addresses the read and the write reach different registers. Address 1 reads the error code and writes a features byte that cannot be read back. Address 7 reads status and writes a command.

Sector data passes through a whole-sector buffer. The host reaches it through the data port at address 0, and each access moves to the next byte. A read command copies the addressed sector from a small internal sector array into the buffer. The host then drains the buffer. A write command opens the buffer for filling. Only when the last byte arrives is the buffer copied into the array. The strobes go through a selectable synchronizer, and only their falling edges act.

Top module: `cf_taskfile_emu`

## Requirements
- R1: After reset, status (address 7) reads 0x40, and the error register (address 1), the registers at addresses 2 to 6 and host_rdata all read 0x00.
- R2: Addresses 2 (count), 3 (sector number), 4 (cylinder low), 5 (cylinder high) and 6 (card/head) store the byte written and return it on a read.
- R3: A write to address 1 loads a hidden features byte. It changes neither the error code read at address 1 nor any other readable register.
- R4: A write to address 7 is a command. A read of address 7 returns status with busy in bit 7, ready (the inverse of busy) in bit 6, data-request in bit 3, error in bit 0, and zero in the other bits.
- R5: Command 0x20 (read sector) shows busy (status 0x80) for one cycle per buffer byte while the sector is copied. Status then reads 0x48, and the 512 data-port reads return the sector's bytes in order from byte 0. Status returns to 0x40 after the last of them.
- R6: Command 0x30 (write sector) gives status 0x48 at once. Each data-port write stores the next buffer byte from byte 0. After the 512th write, status shows busy (0x80) while the buffer is committed, then 0x40.
- R7: A write transfer that is cut short by a new command before 512 bytes have arrived leaves the stored sector unchanged.
- R8: Any other command byte sets status to 0x41 and the error register to 0x04, and starts no transfer. The next accepted command clears both.
- R9: The sector index is {card/head[3:0], cylinder high, cylinder low, sector number}. Card/head bits 7:4 are ignored. An index of NUM_SECTORS or more sets status 0x41 and the error register to 0x10.
- R10: Outside a transfer, a data-port read returns 0x00 and a data-port write is ignored. Neither moves the byte position.
- R11: A command written while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Task-file register select |
| host_oe_n | input | 1 | Active-low read strobe; its falling edge performs the read |
| host_we_n | input | 1 | Active-low write strobe; its falling edge performs the write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Data captured by the last read strobe |

## Verification
A byte-position counter that is off by one shows up on the first data-port read after a read command, as a shifted pattern. A skipped or repeated step shows up as a mismatch somewhere within the 512-byte drain. A wrong latched sector index, or a commit that starts early, shows nothing while it happens. It appears only when a later read command returns the sector, roughly a thousand cycles on. The bench therefore always reads data back through a fresh command. A wrong state-machine state shows in the status byte on the very next read strobe.

// File: rtl/cf_tf_pkg.sv
package cf_tf_pkg;

   typedef enum logic [2:0] {
      TF_IDLE,
      TF_FILL,
      TF_XRD,
      TF_XWR,
      TF_COMMIT
   } tf_state_e;

   localparam logic [2:0] A_DATA    = 3'd0;
   localparam logic [2:0] A_ERRFEAT = 3'd1;
   localparam logic [2:0] A_COUNT   = 3'd2;
   localparam logic [2:0] A_SECNO   = 3'd3;
   localparam logic [2:0] A_CYLLO   = 3'd4;
   localparam logic [2:0] A_CYLHI   = 3'd5;
   localparam logic [2:0] A_HEAD    = 3'd6;
   localparam logic [2:0] A_CMDSTAT = 3'd7;

   localparam logic [7:0] EC_ABORT  = 8'h04;
   localparam logic [7:0] EC_NOSECT = 8'h10;

   typedef struct packed {
      logic [7:0] count;
      logic [7:0] secno;
      logic [7:0] cyllo;
      logic [7:0] cylhi;
      logic [7:0] head;
   } tf_regs_t;

endpackage

// File: rtl/cf_tf_strobe.sv
module cf_tf_strobe #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strb_n,
   output logic fall
);
   logic lvl;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = strb_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= strb_n;
               for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign lvl = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl;
   end

   assign fall = prev & ~lvl;

   // a fall is a single-cycle event (R5 single access per strobe)
   assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/cf_tf_mem.sv
module cf_tf_mem #(
   parameter int AW = 9,
   parameter int DW = 8,
   localparam int DEPTH = 2 ** AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cf_tf_regs.sv
module cf_tf_regs import cf_tf_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_fire,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output tf_regs_t   regs
);
   logic [7:0] features;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs     <= '0;
         features <= '0;
      end else if (wr_fire) begin
         unique case (addr)
            A_ERRFEAT: features   <= wdata;
            A_COUNT:   regs.count <= wdata;
            A_SECNO:   regs.secno <= wdata;
            A_CYLLO:   regs.cyllo <= wdata;
            A_CYLHI:   regs.cylhi <= wdata;
            A_HEAD:    regs.head  <= wdata;
            default: ;
         endcase
      end
   end

   // features write is invisible to the readable set (R3)
   assert_feat_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && addr == A_ERRFEAT) |=> ($stable(regs) && features == $past(wdata)));
endmodule

// File: rtl/cf_tf_ctrl.sv
module cf_tf_ctrl import cf_tf_pkg::*; #(
   parameter int          SECTOR_BYTES = 512,
   parameter int          NUM_SECTORS  = 4,
   parameter logic [7:0]  CMD_READ     = 8'h20,
   parameter logic [7:0]  CMD_WRITE    = 8'h30,
   localparam int CNT_W = $clog2(SECTOR_BYTES),
   localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_fire,
   input  logic [7:0]             cmd,
   input  logic [27:0]            lba,
   input  logic                   host_rd,
   input  logic                   host_wr,
   input  logic [7:0]             host_wdata,
   input  logic [7:0]             store_rdata,
   input  logic [7:0]             buf_rdata,
   output logic                   busy,
   output logic                   drq,
   output logic                   xfer_rd,
   output logic                   err_bit,
   output logic [7:0]             err_reg,
   output logic                   buf_we,
   output logic [CNT_W-1:0]       buf_addr,
   output logic [7:0]             buf_wdata,
   output logic                   st_we,
   output logic [SEC_W+CNT_W-1:0] st_addr,
   output logic [7:0]             st_wdata
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SECTOR_BYTES - 1);

   tf_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [SEC_W-1:0] sec_q;
   logic             accept;
   logic             lba_ok;

   assign busy    = (state == TF_FILL) || (state == TF_COMMIT);
   assign drq     = (state == TF_XRD)  || (state == TF_XWR);
   assign xfer_rd = (state == TF_XRD);
   assign accept  = cmd_fire && !busy;
   assign lba_ok  = lba < 28'(NUM_SECTORS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TF_IDLE;
         cnt     <= '0;
         sec_q   <= '0;
         err_bit <= 1'b0;
         err_reg <= '0;
      end else if (accept) begin
         cnt     <= '0;
         err_bit <= 1'b0;
         err_reg <= '0;
         if (cmd == CMD_READ || cmd == CMD_WRITE) begin
            if (lba_ok) begin
               state <= (cmd == CMD_READ) ? TF_FILL : TF_XWR;
               sec_q <= lba[SEC_W-1:0];
            end else begin
               state   <= TF_IDLE;
               err_bit <= 1'b1;
               err_reg <= EC_NOSECT;
            end
         end else begin
            state   <= TF_IDLE;
            err_bit <= 1'b1;
            err_reg <= EC_ABORT;
         end
      end else begin
         unique case (state)
            TF_FILL: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= TF_XRD;
            end
            TF_XRD: if (host_rd) begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= TF_IDLE;
            end
            TF_XWR: if (host_wr) begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= TF_COMMIT;
            end
            TF_COMMIT: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= TF_IDLE;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      buf_addr  = cnt;
      buf_we    = 1'b0;
      buf_wdata = host_wdata;
      if (state == TF_FILL) begin
         buf_we    = 1'b1;
         buf_wdata = store_rdata;
      end else if (state == TF_XWR) begin
         buf_we    = host_wr;
      end
   end

   assign st_addr  = {sec_q, cnt};
   assign st_we    = (state == TF_COMMIT);
   assign st_wdata = buf_rdata;

   // commit begins only right after the final buffer byte was written (R7)
   assert_commit_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TF_COMMIT && $past(state) != TF_COMMIT) |->
         ($past(state) == TF_XWR && $past(host_wr) && $past(cnt) == LAST));

   // the sector copy walks the buffer one byte per cycle (R5)
   assert_fill_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TF_FILL && $past(state) == TF_FILL) |-> cnt == $past(cnt) + CNT_W'(1));

   // a command arriving during busy leaves the error state alone (R11)
   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_fire) |=> (err_bit == $past(err_bit) && err_reg == $past(err_reg)));

   // error flag always carries a defined code (R8, R9)
   assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_bit |-> (err_reg == EC_ABORT || err_reg == EC_NOSECT));
endmodule

// File: rtl/cf_taskfile_emu.sv
module cf_taskfile_emu import cf_tf_pkg::*; #(
   parameter int         SECTOR_BYTES = 512,
   parameter int         NUM_SECTORS  = 4,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [7:0] CMD_READ     = 8'h20,
   parameter logic [7:0] CMD_WRITE    = 8'h30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] host_addr,
   input  logic       host_oe_n,
   input  logic       host_we_n,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata
);
   localparam int CNT_W = $clog2(SECTOR_BYTES);
   localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
   localparam int ST_AW = SEC_W + CNT_W;

   if (SECTOR_BYTES < 2 || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_sb
      $error("SECTOR_BYTES must be a power of two");
   end
   if (NUM_SECTORS < 1 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_ns
      $error("NUM_SECTORS must be a power of two");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic oe_fall, we_fall;
   logic wr_fire, rd_fire, cmd_fire, host_rd, host_wr;
   tf_regs_t regs;
   logic busy, drq, xfer_rd, err_bit;
   logic [7:0] err_reg, status, rd_mux;
   logic buf_we, st_we;
   logic [CNT_W-1:0] buf_addr;
   logic [7:0] buf_wdata, buf_rdata, st_wdata, st_rdata;
   logic [ST_AW-1:0] st_addr;
   logic [27:0] lba;

   cf_tf_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_oe (
      .clk(clk), .rst_n(rst_n), .strb_n(host_oe_n), .fall(oe_fall));
   cf_tf_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_we (
      .clk(clk), .rst_n(rst_n), .strb_n(host_we_n), .fall(we_fall));

   assign wr_fire  = we_fall;
   assign rd_fire  = oe_fall;
   assign cmd_fire = we_fall && host_addr == A_CMDSTAT;
   assign host_rd  = oe_fall && host_addr == A_DATA;
   assign host_wr  = we_fall && host_addr == A_DATA;

   cf_tf_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
      .addr(host_addr), .wdata(host_wdata), .regs(regs));

   assign lba = {regs.head[3:0], regs.cylhi, regs.cyllo, regs.secno};

   cf_tf_ctrl #(
      .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS),
      .CMD_READ(CMD_READ), .CMD_WRITE(CMD_WRITE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd(host_wdata),
      .lba(lba), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .store_rdata(st_rdata), .buf_rdata(buf_rdata),
      .busy(busy), .drq(drq), .xfer_rd(xfer_rd), .err_bit(err_bit),
      .err_reg(err_reg), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .st_we(st_we), .st_addr(st_addr),
      .st_wdata(st_wdata));

   cf_tf_mem #(.AW(CNT_W), .DW(8)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
      .raddr(buf_addr), .rdata(buf_rdata));

   cf_tf_mem #(.AW(ST_AW), .DW(8)) u_store (
      .clk(clk), .we(st_we), .waddr(st_addr), .wdata(st_wdata),
      .raddr(st_addr), .rdata(st_rdata));

   assign status = {busy, ~busy, 2'b00, drq, 2'b00, err_bit};

   always_comb begin
      unique case (host_addr)
         A_DATA:    rd_mux = xfer_rd ? buf_rdata : 8'h00;
         A_ERRFEAT: rd_mux = err_reg;
         A_COUNT:   rd_mux = regs.count;
         A_SECNO:   rd_mux = regs.secno;
         A_CYLLO:   rd_mux = regs.cyllo;
         A_CYLHI:   rd_mux = regs.cylhi;
         A_HEAD:    rd_mux = regs.head;
         default:   rd_mux = status;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       host_rdata <= '0;
      else if (rd_fire) host_rdata <= rd_mux;
   end

   // data-port reads outside a read transfer give zero (R10)
   assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !xfer_rd) |=> host_rdata == 8'h00);

   // busy and data-request never show together in status (R4)
   assert_status_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && host_addr == A_CMDSTAT) |=> !(host_rdata[7] && host_rdata[3]));
endmodule

// File: tb/cf_taskfile_emu_tb.sv
module cf_taskfile_emu_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic       host_oe_n = 1'b1;
   logic       host_we_n = 1'b1;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   cf_taskfile_emu u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_oe_n(host_oe_n),
      .host_we_n(host_we_n), .host_wdata(host_wdata), .host_rdata(host_rdata));

   function automatic logic [7:0] pat(int seed, int i);
      return 8'((i * seed) + (i >> 3) + seed);
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d;
      host_we_n = 1'b0;
      repeat (4) @(negedge clk);
      host_we_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_read(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      host_oe_n = 1'b0;
      repeat (4) @(negedge clk);
      d = host_rdata;
      host_oe_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int k = 0; k < 400; k++) begin
         bus_read(3'd7, s);
         if (!s[7]) return;
      end
   endtask

   task automatic set_lba(logic [7:0] sec, logic [7:0] clo, logic [7:0] chi, logic [7:0] hd);
      bus_write(3'd3, sec); bus_write(3'd4, clo);
      bus_write(3'd5, chi); bus_write(3'd6, hd);
   endtask

   task automatic fill_sector(int seed, int nbytes);
      for (int i = 0; i < nbytes; i++) bus_write(3'd0, pat(seed, i));
   endtask

   task automatic drain_compare(string req, int seed);
      logic [7:0] d;
      int bad = 0;
      logic [7:0] first_act = 0, first_exp = 0;
      for (int i = 0; i < 512; i++) begin
         bus_read(3'd0, d);
         if (d !== pat(seed, i) && bad == 0) begin
            first_act = d; first_exp = pat(seed, i);
         end
         if (d !== pat(seed, i)) bad++;
      end
      n_tests++;
      if (bad != 0) begin
         n_fail++;
         $display("FAIL %s: %0d bytes wrong, first got %02h expected %02h",
                  req, bad, first_act, first_exp);
      end
   endtask

   task automatic write_sector(logic [7:0] sec, int seed);
      logic [7:0] s;
      set_lba(sec, 8'h00, 8'h00, 8'h00);
      bus_write(3'd7, 8'h30);
      bus_read(3'd7, s); check("R6 drq after write cmd", s, 8'h48);
      fill_sector(seed, 512);
      bus_read(3'd7, s); check("R6 busy during commit", s, 8'h80);
      wait_idle();
      bus_read(3'd7, s); check("R6 ready after commit", s, 8'h40);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 rdata after reset", host_rdata, 8'h00);
      bus_read(3'd7, d); check("R1 status", d, 8'h40);
      bus_read(3'd1, d); check("R1 error", d, 8'h00);
      for (int a = 2; a <= 6; a++) begin
         bus_read(3'(a), d); check("R1 register", d, 8'h00);
      end
   endtask

   task automatic t_regs();
      logic [7:0] d;
      for (int a = 2; a <= 6; a++) bus_write(3'(a), 8'(8'h31 * a));
      for (int a = 2; a <= 6; a++) begin
         bus_read(3'(a), d); check("R2 readback", d, 8'(8'h31 * a));
      end
   endtask

   task automatic t_errfeat();
      logic [7:0] d;
      bus_write(3'd1, 8'hA5);
      bus_read(3'd1, d); check("R3 error not features", d, 8'h00);
      bus_read(3'd2, d); check("R3 count untouched", d, 8'h62);
      bus_read(3'd7, d); check("R3 status untouched", d, 8'h40);
   endtask

   task automatic t_read(string req, logic [7:0] sec, int seed);
      logic [7:0] s;
      set_lba(sec, 8'h00, 8'h00, 8'h00);
      bus_write(3'd7, 8'h20);
      bus_read(3'd7, s); check("R5 busy during fill", s, 8'h80);
      wait_idle();
      bus_read(3'd7, s); check("R5 drq after fill", s, 8'h48);
      drain_compare(req, seed);
      bus_read(3'd7, s); check("R5 ready after drain", s, 8'h40);
   endtask

   task automatic t_partial();
      logic [7:0] s;
      set_lba(8'd3, 8'h00, 8'h00, 8'h00);
      bus_write(3'd7, 8'h30);
      fill_sector(99, 100);
      bus_read(3'd7, s); check("R7 still awaiting data", s, 8'h48);
      t_read("R7 partial write committed nothing", 8'd3, 11);
   endtask

   task automatic t_badcmd();
      logic [7:0] s;
      bus_write(3'd7, 8'h55);
      bus_read(3'd7, s); check("R8 status on unknown cmd", s, 8'h41);
      bus_read(3'd1, s); check("R8 abort code", s, 8'h04);
      bus_write(3'd7, 8'h30);
      bus_read(3'd7, s); check("R8 error cleared by next cmd", s, 8'h48);
      bus_read(3'd1, s); check("R8 error reg cleared", s, 8'h00);
      bus_write(3'd7, 8'h66);
   endtask

   task automatic t_lba();
      logic [7:0] s;
      set_lba(8'd0, 8'h00, 8'h01, 8'h00);
      bus_write(3'd7, 8'h20);
      bus_read(3'd7, s); check("R9 cylinder high out of range", s, 8'h41);
      bus_read(3'd1, s); check("R9 no-sector code", s, 8'h10);
      set_lba(8'd0, 8'h00, 8'h00, 8'h01);
      bus_write(3'd7, 8'h20);
      bus_read(3'd7, s); check("R9 head nibble out of range", s, 8'h41);
      set_lba(8'd4, 8'h00, 8'h00, 8'h00);
      bus_write(3'd7, 8'h20);
      bus_read(3'd1, s); check("R9 sector number at limit", s, 8'h10);
      set_lba(8'd3, 8'h00, 8'h00, 8'hE0);
      bus_write(3'd7, 8'h20);
      wait_idle();
      bus_read(3'd7, s); check("R9 upper head bits ignored", s, 8'h48);
      drain_compare("R9 sector 3 via head E0", 11);
   endtask

   task automatic t_outside();
      logic [7:0] d;
      bus_read(3'd0, d); check("R10 idle data read", d, 8'h00);
      bus_write(3'd0, 8'h77);
      t_read("R10 idle write ignored, position unmoved", 8'd2, 3);
   endtask

   task automatic t_busycmd();
      logic [7:0] s;
      set_lba(8'd2, 8'h00, 8'h00, 8'h00);
      bus_write(3'd7, 8'h20);
      bus_write(3'd7, 8'h55);
      wait_idle();
      bus_read(3'd7, s); check("R11 cmd while busy ignored", s, 8'h48);
      bus_read(3'd1, s); check("R11 no abort code", s, 8'h00);
      drain_compare("R11 read completes", 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_regs();
      t_errfeat();
      write_sector(8'd2, 3);
      write_sector(8'd3, 11);
      t_read("R5 sector 2 contents", 8'd2, 3);
      t_read("R5 sector 3 contents", 8'd3, 11);
      t_partial();
      t_badcmd();
      t_lba();
      t_outside();
      t_busycmd();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule